// File: doc/BRIEF.md
# Early-Release Filler Word Stuffer

This block runs once the main configuration stream has drained into the configuration data path. It then keeps that path supplied with filler words until the target device reports early user mode. It also gives up after a bounded wall-clock time. While it is pushing filler, it overrides the clock-to-data ratio to the 1x setting. When it leaves, by success or by timeout, it puts the previously programmed ratio back.

A start pulse launches a run. The block saves the ratio value presented on `ratio_cur_i` and writes the 1x setting through `ratio_o`/`ratio_we_o`. It then alternates between checking the early-user-mode status and offering one all-ones word on a valid/ready handshake, and it waits a fixed pacing interval after each accepted word. The run ends with a restore write of the saved ratio, followed one cycle later by a single-cycle `done_o` or `timeout_o` pulse. `word_count_o` holds the number of accepted filler words until the next run starts.

The controller is a seven-state machine:
- `ST_IDLE` waits for start and moves to `ST_FORCE`.
- `ST_FORCE` issues the 1x write and moves to `ST_CHECK`.
- `ST_CHECK` moves to `ST_RESTORE` with success if early user mode is high. Otherwise it moves to `ST_RESTORE` with timeout if the window has expired, and to `ST_SEND` if not.
- `ST_SEND` moves to `ST_PACE` on an accepted handshake. It moves to `ST_RESTORE` with timeout if the window expires while the word is unaccepted.
- `ST_PACE` moves to `ST_CHECK` once the pacing interval ends.
- `ST_RESTORE` issues the restore write and moves to `ST_FINISH`.
- `ST_FINISH` pulses the result and returns to `ST_IDLE`.

Top module: `early_sync_stuffer`

## Requirements
- R1: The ratio value on `ratio_cur_i` is captured in the cycle the start pulse is taken. In the next cycle `ratio_we_o` is high for one cycle with `ratio_o` equal to the 1x encoding (parameter `RATIO_1X`, default 0).
- R2: Every filler word offered has all `DATA_W` bits set to 1. Once early user mode has been high when a word is taken, at most one further word is accepted.
- R3: An offered word keeps `fill_valid_o` high until `fill_ready_i` accepts it. The only exception is a timeout exit, which withdraws it.
- R4: With `fill_ready_i` held high, successive accepted words are exactly `PACE_CYCLES + 2` clock cycles apart.
- R5: A run ends with `timeout_o` when, before early user mode is seen, more than `TIMEOUT_MS` millisecond ticks have arrived since the run began. The pulse comes no later than `PACE_CYCLES + 6` cycles after the tick that exceeds the limit.
- R6: Every run ends with a second ratio write carrying the captured value. This write falls exactly one cycle before the result pulse.
- R7: `word_count_o` equals the number of accepted handshakes of the run, is zero before the first run, and holds after completion until the next start.
- R8: If early user mode is high when a run starts, no word is offered. The ratio is forced and restored, and `done_o` pulses in the fourth cycle after the start edge with a count of zero.
- R9: A start pulse while a run is in progress has no effect. The run still makes exactly two ratio writes and restores the first captured value.
- R10: `done_o` and `timeout_o` are never high together, each lasts exactly one cycle, and each run produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a run when idle |
| early_user_i | input | 1 | Early user mode status from the target |
| ms_tick_i | input | 1 | One-cycle pulse per elapsed millisecond |
| ratio_cur_i | input | RATIO_W | Currently programmed clock-to-data ratio |
| fill_data_o | output | DATA_W | Filler word (all ones while valid) |
| fill_valid_o | output | 1 | Filler word offered |
| fill_ready_i | input | 1 | Configuration path accepts the word |
| ratio_o | output | RATIO_W | Ratio value to program |
| ratio_we_o | output | 1 | Write strobe for `ratio_o` |
| done_o | output | 1 | Run ended with early user mode seen |
| timeout_o | output | 1 | Run ended by timeout |
| word_count_o | output | CNT_W | Filler words accepted in the last run |

## Verification
The 1x write is due one cycle after the start edge, and the restore write is due exactly one cycle before the result pulse. With early user mode high at start, the result is due four cycles after the start edge. Accepted words are due `PACE_CYCLES + 2` cycles apart, and a timeout is due within `PACE_CYCLES + 6` cycles after the limit-breaking tick. The bench drives inputs 2 ns after each rising edge and samples every output at the falling edge. A falling-edge monitor records each handshake, ratio write, tick and result with its cycle number, and the checks compare those cycle stamps against the bench's expected distances.

// File: rtl/sstuff_pkg.sv
package sstuff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FORCE,
        ST_CHECK,
        ST_SEND,
        ST_PACE,
        ST_RESTORE,
        ST_FINISH
    } stuff_state_t;

    typedef enum logic {
        RES_OK,
        RES_TIMEOUT
    } stuff_result_t;

endpackage

// File: rtl/sstuff_pacer.sv
module sstuff_pacer #(
    parameter int PACE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int PW = (PACE_CYCLES > 1) ? $clog2(PACE_CYCLES) : 1;
    localparam logic [PW-1:0] LOAD_V = PW'(PACE_CYCLES - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_V;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == '0);

    // R4
    pace_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> !load_i);

    // R4
    pace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q <= LOAD_V));

endmodule

// File: rtl/sstuff_ms_window.sv
module sstuff_ms_window #(
    parameter int TIMEOUT_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int MW = $clog2(TIMEOUT_MS + 2);
    localparam logic [MW-1:0] LIMIT = MW'(TIMEOUT_MS + 1);

    logic [MW-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (clear_i) begin
            ms_q <= '0;
        end else if (run_i && tick_i && ms_q != LIMIT) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    assign expired_o = (ms_q == LIMIT);

    // R5
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i) |=> expired_o);

    // R5
    tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !expired_o);

endmodule

// File: rtl/sstuff_word_tally.sv
module sstuff_word_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (inc_i && count_o != '1) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R7
    tally_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clear_i) |=> $stable(count_o));

    // R7
    tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clear_i && count_o != '1) |=> (count_o != $past(count_o)));

endmodule

// File: rtl/early_sync_stuffer.sv
module early_sync_stuffer
    import sstuff_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int RATIO_W     = 2,
    parameter int RATIO_1X    = 0,
    parameter int PACE_CYCLES = 100000,
    parameter int TIMEOUT_MS  = 1000,
    parameter int CNT_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               early_user_i,
    input  logic               ms_tick_i,
    input  logic [RATIO_W-1:0] ratio_cur_i,
    output logic [DATA_W-1:0]  fill_data_o,
    output logic               fill_valid_o,
    input  logic               fill_ready_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               ratio_we_o,
    output logic               done_o,
    output logic               timeout_o,
    output logic [CNT_W-1:0]   word_count_o
);
    localparam logic [RATIO_W-1:0] RATIO_1X_V = RATIO_W'(RATIO_1X);
    localparam logic [DATA_W-1:0]  FILL_WORD  = '1;

    stuff_state_t  state_q, state_d;
    stuff_result_t result_q, result_d;
    logic [RATIO_W-1:0] saved_ratio;

    logic accept;
    logic pace_exp;
    logic tmo_exp;
    logic window_run;

    assign accept     = (state_q == ST_SEND) && fill_ready_i;
    assign window_run = (state_q == ST_CHECK) || (state_q == ST_SEND) || (state_q == ST_PACE);

    sstuff_pacer #(
        .PACE_CYCLES(PACE_CYCLES)
    ) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .run_i    (state_q == ST_PACE),
        .expired_o(pace_exp)
    );

    sstuff_ms_window #(
        .TIMEOUT_MS(TIMEOUT_MS)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q == ST_FORCE),
        .run_i    (window_run),
        .tick_i   (ms_tick_i),
        .expired_o(tmo_exp)
    );

    sstuff_word_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(state_q == ST_FORCE),
        .inc_i  (accept),
        .count_o(word_count_o)
    );

    // Next-state and result decision
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_FORCE;
            end
            ST_FORCE: begin
                state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (early_user_i) begin
                    state_d  = ST_RESTORE;
                    result_d = RES_OK;
                end else if (tmo_exp) begin
                    state_d  = ST_RESTORE;
                    result_d = RES_TIMEOUT;
                end else begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (fill_ready_i) begin
                    state_d = ST_PACE;
                end else if (tmo_exp) begin
                    state_d  = ST_RESTORE;
                    result_d = RES_TIMEOUT;
                end
            end
            ST_PACE: begin
                if (pace_exp) state_d = ST_CHECK;
            end
            ST_RESTORE: begin
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and saved ratio
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            result_q    <= RES_OK;
            saved_ratio <= '0;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            if (state_q == ST_IDLE && start_i) begin
                saved_ratio <= ratio_cur_i;
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        fill_valid_o = 1'b0;
        fill_data_o  = '0;
        ratio_we_o   = 1'b0;
        ratio_o      = saved_ratio;
        done_o       = 1'b0;
        timeout_o    = 1'b0;
        unique case (state_q)
            ST_FORCE: begin
                ratio_we_o = 1'b1;
                ratio_o    = RATIO_1X_V;
            end
            ST_SEND: begin
                fill_valid_o = 1'b1;
                fill_data_o  = FILL_WORD;
            end
            ST_RESTORE: begin
                ratio_we_o = 1'b1;
            end
            ST_FINISH: begin
                done_o    = (result_q == RES_OK);
                timeout_o = (result_q == RES_TIMEOUT);
            end
            default: begin
            end
        endcase
    end

    // R1
    force_1x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (ratio_we_o && ratio_o == RATIO_1X_V));

    // R3
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_o && !fill_ready_i && !tmo_exp) |=> fill_valid_o);

    // R2
    fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_o && fill_ready_i) |-> (fill_data_o == FILL_WORD));

    // R6
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> ($past(ratio_we_o) && $past(ratio_o) == saved_ratio));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(saved_ratio));

    // R10
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, timeout_o}));

    // R10
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |=> !(done_o || timeout_o));

endmodule

// File: tb/tb_early_sync_stuffer.sv
module tb_early_sync_stuffer;
    localparam int DW = 32;
    localparam int RW = 2;
    localparam int P  = 10;
    localparam int T  = 3;
    localparam int CW = 16;
    localparam int TICK_PER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic early = 1'b0;
    logic tick = 1'b0;
    logic ready = 1'b0;
    logic [RW-1:0] rcur = '0;
    logic [DW-1:0] fdata;
    logic fv, rwe, done, tmo;
    logic [RW-1:0] ro;
    logic [CW-1:0] wcnt;

    early_sync_stuffer #(
        .DATA_W(DW), .RATIO_W(RW), .RATIO_1X(0),
        .PACE_CYCLES(P), .TIMEOUT_MS(T), .CNT_W(CW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .early_user_i(early),
        .ms_tick_i(tick), .ratio_cur_i(rcur), .fill_data_o(fdata),
        .fill_valid_o(fv), .fill_ready_i(ready), .ratio_o(ro),
        .ratio_we_o(rwe), .done_o(done), .timeout_o(tmo), .word_count_o(wcnt)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ready_pct = 100;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        tick  = ((cyc % TICK_PER) == 0);
        ready = ($urandom_range(99) < ready_pct);
    end

    // Monitor state for the current run
    int s0 = 1 << 30;
    int accs, post_early, drops, bad_data, wr_n, ticks, tcyc;
    int done_n, tmo_n, res_cyc, last_acc, gap_min, gap_max;
    logic [RW-1:0] wr_val [0:3];
    logic prev_v = 1'b0, prev_r = 1'b0;

    function automatic int exp_gap(input int pace);
        return pace + 2;
    endfunction

    function automatic bit exp_timeout(input int early_at);
        return early_at < 0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (fv && ready) begin
                accs++;
                if (fdata != '1) bad_data++;
                if (early) post_early++;
                if (last_acc >= 0) begin
                    if (cyc - last_acc < gap_min) gap_min = cyc - last_acc;
                    if (cyc - last_acc > gap_max) gap_max = cyc - last_acc;
                end
                last_acc = cyc;
            end
            if (prev_v && !prev_r && !fv) drops++;
            prev_v = fv;
            prev_r = ready;
            if (rwe) begin
                if (wr_n < 4) wr_val[wr_n] = ro;
                wr_n++;
            end
            if (tick && (cyc + 1 >= s0 + 2)) begin
                ticks++;
                if (ticks == T + 1) tcyc = cyc;
            end
            if (done) begin done_n++; res_cyc = cyc; end
            if (tmo)  begin tmo_n++;  res_cyc = cyc; end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        accs = 0; post_early = 0; drops = 0; bad_data = 0; wr_n = 0;
        ticks = 0; tcyc = -1; done_n = 0; tmo_n = 0; res_cyc = -1;
        last_acc = -1; gap_min = 1 << 30; gap_max = 0;
        s0 = 1 << 30;
    endtask

    // Pulse start; returns after the edge that samples it
    task automatic launch(input logic [RW-1:0] rv);
        @(posedge clk); #2;
        clear_mon();
        rcur  = rv;
        start = 1'b1;
        @(posedge clk); #1;
        s0 = cyc;
        #1;
        start = 1'b0;
    endtask

    task automatic run_case(input logic [RW-1:0] rstart, input logic [RW-1:0] rlater,
                            input int pct, input int early_at, input int again,
                            input bit pace_check);
        int lim;
        ready_pct = pct;
        early = 1'b0;
        launch(rstart);
        lim = 0;
        for (int k = 0; k < 4000 && (done_n + tmo_n) == 0; k++) begin
            @(posedge clk); #2;
            start = 1'b0;
            if (k == 1) rcur = rlater;
            if (k == early_at) early = 1'b1;
            if (k == again) start = 1'b1;
            lim = k;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(done_n + tmo_n == 1, "R10 one result per run", done_n + tmo_n, 1);
        chk(tmo_n == int'(exp_timeout(early_at)), "R5 timeout outcome", tmo_n, int'(exp_timeout(early_at)));
        chk(wr_n == 2, "R9 two ratio writes", wr_n, 2);
        chk(wr_val[0] == 2'd0, "R1 forced 1x value", wr_val[0], 0);
        chk(wr_val[1] == rstart, "R6 restored captured ratio", wr_val[1], rstart);
        chk(int'(wcnt) == accs, "R7 count equals accepted words", wcnt, accs);
        chk(bad_data == 0, "R2 filler all ones", bad_data, 0);
        chk(post_early <= 1, "R2 words after early", post_early, 1);
        chk(drops == 0 || (drops == 1 && tmo_n == 1), "R3 word held until ready", drops, 0);
        if (tmo_n == 1) begin
            chk(tcyc >= 0 && res_cyc > tcyc && res_cyc - tcyc <= P + 6,
                "R5 timeout latency", res_cyc - tcyc, P + 6);
        end
        if (pace_check) begin
            chk(accs >= 2 && gap_min == exp_gap(P) && gap_max == exp_gap(P),
                "R4 pacing gap", gap_max, exp_gap(P));
        end
        repeat (20) @(negedge clk);
        #1;
        chk(int'(wcnt) == accs, "R7 count holds after run", wcnt, accs);
        early = 1'b0;
        if (lim < 0) $display("unreachable");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_mon();
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!fv && !rwe && !done && !tmo, "R10 idle after reset", {fv, rwe, done, tmo}, 0);
        chk(wcnt == '0, "R7 count zero after reset", wcnt, 0);

        // R8: early user mode already high at start, exact timing
        ready_pct = 100;
        early = 1'b1;
        launch(2'd2);
        @(negedge clk); #1;
        chk(rwe && ro == 2'd0, "R1 force strobe one cycle after start", {rwe, ro}, 4);
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk(rwe && ro == 2'd2, "R6 restore strobe before result", {rwe, ro}, 6);
        @(negedge clk); #1;
        chk(done && !tmo, "R8 done in fourth cycle", {done, tmo}, 2);
        chk(wcnt == '0 && accs == 0, "R8 zero words", accs, 0);
        @(negedge clk); #1;
        chk(!done && !tmo, "R10 single-cycle result", {done, tmo}, 0);
        early = 1'b0;

        // R4/R5: ready always high, never early -> timeout, exact pacing
        run_case(2'd3, 2'd1, 100, -1, -1, 1'b1);

        // R2: early arrives after a few words, ready always high
        run_case(2'd1, 2'd2, 100, 30, -1, 1'b0);

        // Randomized runs with back-pressure, busy restarts (R9) and ratio changes
        for (int n = 0; n < 10; n++) begin
            logic [RW-1:0] rs, rl;
            int pct, ea;
            rs  = RW'($urandom_range(3));
            rl  = RW'(rs + RW'(1 + $urandom_range(2)));
            pct = 30 + $urandom_range(70);
            ea  = ($urandom_range(3) == 0) ? -1 : $urandom_range(60);
            run_case(rs, rl, pct, ea, 5, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule